// File: doc/BRIEF.md
# Dual-Mode Instruction Expander

This block sits between instruction fetch and decode in a core that runs two instruction encodings: a full 32-bit set and a compact 16-bit set. Both encodings can sit mixed in the same program image. Every cycle the block takes one aligned 32-bit fetch word and hands decode one full-width instruction with a valid flag. The expansion adds no pipeline stage.

In full mode a fetch word passes through unchanged. In compact mode the word holds two 16-bit slots. The lower slot is handled first and the upper slot second. Each slot is translated through a computed opcode table into exactly one full-width instruction. The active encoding changes only on explicit exchange instructions, one per direction, so code can switch encodings at any single instruction.

Three compact instructions control the block rather than doing work:
- A padding no-op that is dropped.
- A prefix that supplies high immediate bits to the instruction after it.
- A move that can address all sixteen registers.

A redirect flush resets the slot pointer and the prefix, and loads the encoding of the branch target.

Top module: `dual_isa_expander`

## Requirements
- R1: After reset the block is in full mode, the slot pointer is at the lower half, and no prefix is pending. mode_o is 0 and fetch_ready_o is 1.
- R2: In full mode, a fetched word whose opcode bits [31:25] are not 7'h01 appears unchanged on instr_o with instr_valid_o high and fetch_ready_o high, in the same cycle.
- R3: In full mode, a fetched word with opcode bits [31:25] = 7'h01 is consumed and not issued. The next word is handled in compact mode (mode_o = 1).
- R4: In compact mode the lower half [15:0] is handled first with fetch_ready_o low. The upper half [31:16] is handled in the next valid cycle with fetch_ready_o high.
- R5: A compact slot has opcode [15:9], field A [8:6], field B [5:3] and field C [2:0]. When the opcode is in 4..63, the output is {T(op), 0,A, 0,B, 0,C, 13'b0}, where T(op) = 4 + ((op-4)*7 mod 124). The output fields are opcode [31:25], rd [24:21], rs1 [20:17], rs2 [16:13] and imm [12:0].
- R6: When the compact opcode is in 64..127 and no prefix is pending, the output is {T(op), 0,A, 0,B, 4'b0, imm}. Here imm is field C sign-extended to 13 bits.
- R7: Compact opcode 3 is a prefix. It issues nothing and stores bits [8:0]. The next issued compact instruction in the 64..127 range gets imm = {stored bits, C[2], C}. Any issued instruction clears the stored bits.
- R8: Compact opcode 2 is a move. It issues {7'h02, rd=[7:4], rs1=[3:0], 4'b0, 13'b0}.
- R9: Compact opcode 0 is a padding no-op. It issues nothing and uses up its slot.
- R10: Compact opcode 1 issues nothing and returns to full mode. When it sits in the lower half, the upper half is skipped and the word is consumed at once (fetch_ready_o high).
- R11: While flush_i is high, nothing is issued and fetch_ready_o is low. In the next cycle the mode equals flush_mode_i (1 = compact), the slot pointer is at the lower half, and no prefix is pending.
- R12: While fetch_valid_i is low and no flush is active, nothing is issued and the mode, slot pointer and prefix state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Redirect: drop the current word and reload state |
| flush_mode_i | input | 1 | Encoding at the redirect target (1 = compact) |
| fetch_valid_i | input | 1 | fetch_word_i holds a valid aligned word |
| fetch_word_i | input | 32 | Aligned fetch word |
| fetch_ready_o | output | 1 | Current word is fully consumed this cycle |
| instr_valid_o | output | 1 | instr_o carries an instruction for decode |
| instr_o | output | 32 | Full-width instruction |
| mode_o | output | 1 | Current encoding (1 = compact) |

## Verification
Three pairs of functions can meet in one cycle:
- A flush can arrive while a prefix is pending, or while the fetched slot is itself an exchange or a prefix.
- A compact exchange can sit in the lower half, so a mode change and a forced skip of the upper half happen on the same edge.
- A prefix can be followed directly by an immediate instruction, which consumes and clears the stored bits in the cycle it issues.

Directed sequences build each of these pairs on purpose. Random stimulus with frequent flushes and exchange opcodes meets them again many times. A bench model that tracks mode, slot pointer and pending prefix supplies the expected valid flag, instruction, ready and mode for every cycle.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned OP_W    = 7;
  localparam int unsigned RR_W    = 3;   // compact register field
  localparam int unsigned AR_W    = 4;   // full register number
  localparam int unsigned IMM_W   = 13;
  localparam int unsigned SIMM_W  = 3;
  localparam int unsigned EXT_W   = IMM_W - SIMM_W - 1;
  localparam int unsigned NUM_OPS = 2 ** OP_W;
  localparam int unsigned LUT_BASE = 4;
  localparam int unsigned LUT_MULT = 7;

  localparam logic [OP_W-1:0] C_NOP  = 7'h00;
  localparam logic [OP_W-1:0] C_XCHG = 7'h01;
  localparam logic [OP_W-1:0] C_MOVE = 7'h02;
  localparam logic [OP_W-1:0] C_EXT  = 7'h03;
  localparam logic [OP_W-1:0] F_XCHG = 7'h01;
  localparam logic [OP_W-1:0] F_MOVE = 7'h02;

  typedef enum logic [2:0] {K_NOP, K_XCHG, K_MOVE, K_EXT, K_REG, K_IMM} slot_kind_e;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [AR_W-1:0]  rd;
    logic [AR_W-1:0]  rs1;
    logic [AR_W-1:0]  rs2;
    logic [IMM_W-1:0] imm;
  } full_instr_t;

  // bijection of LUT_BASE..NUM_OPS-1 onto itself, low codes reserved
  function automatic logic [OP_W-1:0] lut_entry(int unsigned idx);
    int unsigned v;
    if (idx < LUT_BASE) v = 0;
    else v = LUT_BASE + ((idx - LUT_BASE) * LUT_MULT) % (NUM_OPS - LUT_BASE);
    return v[OP_W-1:0];
  endfunction
endpackage

// File: rtl/dmx_slot_expand.sv
module dmx_slot_expand
  import dmx_pkg::*;
(
  input  logic [HALF_W-1:0] slot_i,
  input  logic              ext_valid_i,
  input  logic [EXT_W-1:0]  ext_bits_i,
  output slot_kind_e        kind_o,
  output logic [WORD_W-1:0] instr_o
);
  logic [OP_W-1:0] lut [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_lut
    assign lut[g] = lut_entry(g);
  end

  logic [OP_W-1:0] op;
  logic [RR_W-1:0] fa, fb, fc;
  full_instr_t     fi;

  assign op = slot_i[HALF_W-1 -: OP_W];
  assign fa = slot_i[3*RR_W-1 -: RR_W];
  assign fb = slot_i[2*RR_W-1 -: RR_W];
  assign fc = slot_i[RR_W-1:0];

  always_comb begin
    fi     = '0;
    kind_o = K_REG;
    case (op)
      C_NOP:  kind_o = K_NOP;
      C_XCHG: kind_o = K_XCHG;
      C_EXT:  kind_o = K_EXT;
      C_MOVE: begin
        kind_o = K_MOVE;
        fi.op  = F_MOVE;
        fi.rd  = slot_i[2*AR_W-1 -: AR_W];
        fi.rs1 = slot_i[AR_W-1:0];
      end
      default: begin
        fi.op  = lut[op];
        fi.rd  = AR_W'(fa);
        fi.rs1 = AR_W'(fb);
        if (op[OP_W-1]) begin
          kind_o = K_IMM;
          if (ext_valid_i) fi.imm = {ext_bits_i, fc[SIMM_W-1], fc};
          else             fi.imm = {{(IMM_W-SIMM_W){fc[SIMM_W-1]}}, fc};
        end else begin
          kind_o = K_REG;
          fi.rs2 = AR_W'(fc);
        end
      end
    endcase
  end

  assign instr_o = fi;
endmodule

// File: rtl/dmx_mode_ctrl.sv
module dmx_mode_ctrl
  import dmx_pkg::*;
#(
  parameter bit RESET_COMPACT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             flush_mode_i,
  input  logic             step_i,
  input  logic             consume_i,
  input  logic             to_compact_i,
  input  logic             to_full_i,
  input  logic             set_ext_i,
  input  logic             clr_ext_i,
  input  logic [EXT_W-1:0] ext_payload_i,
  output logic             compact_o,
  output logic             upper_o,
  output logic             ext_valid_o,
  output logic [EXT_W-1:0] ext_bits_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      compact_o   <= RESET_COMPACT;
      upper_o     <= 1'b0;
      ext_valid_o <= 1'b0;
      ext_bits_o  <= '0;
    end else if (flush_i) begin
      compact_o   <= flush_mode_i;
      upper_o     <= 1'b0;
      ext_valid_o <= 1'b0;
    end else if (step_i) begin
      if (to_compact_i)   compact_o <= 1'b1;
      else if (to_full_i) compact_o <= 1'b0;
      upper_o <= compact_o & ~consume_i;
      if (set_ext_i) begin
        ext_valid_o <= 1'b1;
        ext_bits_o  <= ext_payload_i;
      end else if (clr_ext_i) begin
        ext_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_isa_expander.sv
module dual_isa_expander
  import dmx_pkg::*;
#(
  parameter bit RESET_COMPACT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              flush_mode_i,
  input  logic              fetch_valid_i,
  input  logic [WORD_W-1:0] fetch_word_i,
  output logic              fetch_ready_o,
  output logic              instr_valid_o,
  output logic [WORD_W-1:0] instr_o,
  output logic              mode_o
);
  logic              compact_q, upper_q, ext_valid_q;
  logic [EXT_W-1:0]  ext_bits_q;
  logic [HALF_W-1:0] slot;
  slot_kind_e        kind;
  logic [WORD_W-1:0] exp_instr;
  logic              to_compact, to_full, set_ext, clr_ext, consume, step;

  assign slot = upper_q ? fetch_word_i[WORD_W-1 -: HALF_W] : fetch_word_i[HALF_W-1:0];

  dmx_slot_expand u_slot (
    .slot_i      (slot),
    .ext_valid_i (ext_valid_q),
    .ext_bits_i  (ext_bits_q),
    .kind_o      (kind),
    .instr_o     (exp_instr)
  );

  always_comb begin
    instr_valid_o = 1'b0;
    instr_o       = '0;
    fetch_ready_o = 1'b0;
    to_compact    = 1'b0;
    to_full       = 1'b0;
    set_ext       = 1'b0;
    clr_ext       = 1'b0;
    if (!flush_i) begin
      if (!compact_q) begin
        fetch_ready_o = 1'b1;
        if (fetch_valid_i) begin
          if (fetch_word_i[WORD_W-1 -: OP_W] == F_XCHG) begin
            to_compact = 1'b1;
          end else begin
            instr_valid_o = 1'b1;
            instr_o       = fetch_word_i;
          end
        end
      end else begin
        // exchange in the lower slot turns the upper slot into padding
        fetch_ready_o = upper_q | (kind == K_XCHG);
        if (fetch_valid_i) begin
          case (kind)
            K_XCHG: begin
              to_full = 1'b1;
              clr_ext = 1'b1;
            end
            K_EXT:  set_ext = 1'b1;
            K_NOP:  ;
            default: begin
              instr_valid_o = 1'b1;
              instr_o       = exp_instr;
              clr_ext       = 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign step    = fetch_valid_i & ~flush_i;
  assign consume = fetch_ready_o & fetch_valid_i;

  dmx_mode_ctrl #(.RESET_COMPACT(RESET_COMPACT)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .flush_mode_i  (flush_mode_i),
    .step_i        (step),
    .consume_i     (consume),
    .to_compact_i  (to_compact),
    .to_full_i     (to_full),
    .set_ext_i     (set_ext),
    .clr_ext_i     (clr_ext),
    .ext_payload_i (slot[EXT_W-1:0]),
    .compact_o     (compact_q),
    .upper_o       (upper_q),
    .ext_valid_o   (ext_valid_q),
    .ext_bits_o    (ext_bits_q)
  );

  assign mode_o = compact_q;
endmodule

// File: rtl/dmx_expander_chk.sv
module dmx_expander_chk
  import dmx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              flush_i,
  input logic              flush_mode_i,
  input logic              fetch_valid_i,
  input logic [WORD_W-1:0] fetch_word_i,
  input logic              fetch_ready_o,
  input logic              instr_valid_o,
  input logic [WORD_W-1:0] instr_o,
  input logic              compact_q,
  input logic              upper_q,
  input logic              ext_valid_q
);
  logic live;
  assign live = fetch_valid_i & ~flush_i;

  a_r11_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !instr_valid_o && !fetch_ready_o);

  a_r11_flush_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (compact_q == $past(flush_mode_i)) && !upper_q && !ext_valid_q);

  a_r2_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !compact_q && fetch_word_i[31:25] != F_XCHG) |->
      instr_valid_o && fetch_ready_o && (instr_o == fetch_word_i));

  a_r3_enter_compact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !compact_q && fetch_word_i[31:25] == F_XCHG) |=> compact_q && !upper_q);

  a_r4_lower_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && compact_q && !upper_q && fetch_word_i[15:9] != C_XCHG) |=> upper_q);

  a_r4_upper_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && compact_q && upper_q) |-> fetch_ready_o);

  a_r5_zero_ext_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (compact_q && instr_valid_o && instr_o[31:25] != F_MOVE) |->
      !instr_o[24] && !instr_o[20] && !instr_o[16]);

  a_r10_lower_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && compact_q && !upper_q && fetch_word_i[15:9] == C_XCHG) |->
      fetch_ready_o && !instr_valid_o);

  a_r10_back_to_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && compact_q && fetch_ready_o && !instr_valid_o &&
     (upper_q ? fetch_word_i[31:25] : fetch_word_i[15:9]) == C_XCHG) |=> !compact_q && !upper_q);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !fetch_valid_i) |-> !instr_valid_o);

  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !fetch_valid_i) |=> $stable(compact_q) && $stable(upper_q) && $stable(ext_valid_q));
endmodule

bind dual_isa_expander dmx_expander_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .flush_mode_i  (flush_mode_i),
  .fetch_valid_i (fetch_valid_i),
  .fetch_word_i  (fetch_word_i),
  .fetch_ready_o (fetch_ready_o),
  .instr_valid_o (instr_valid_o),
  .instr_o       (instr_o),
  .compact_q     (compact_q),
  .upper_q       (upper_q),
  .ext_valid_q   (ext_valid_q)
);

// File: tb/dual_isa_expander_test.sv
`timescale 1ns/1ps
module dual_isa_expander_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0, flush_mode_i = 1'b0, fetch_valid_i = 1'b0;
  logic [31:0] fetch_word_i = '0;
  logic        fetch_ready_o, instr_valid_o, mode_o;
  logic [31:0] instr_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic       m_cmp = 1'b0, m_up = 1'b0, m_ev = 1'b0;
  logic [8:0] m_eb = '0;

  always #2 clk = ~clk;

  dual_isa_expander uut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .flush_mode_i(flush_mode_i),
    .fetch_valid_i(fetch_valid_i), .fetch_word_i(fetch_word_i),
    .fetch_ready_o(fetch_ready_o), .instr_valid_o(instr_valid_o),
    .instr_o(instr_o), .mode_o(mode_o)
  );

  function automatic logic [6:0] tbl(logic [6:0] op);
    int v;
    v = 4 + ((int'(op) - 4) * 7) % 124;
    return v[6:0];
  endfunction

  function automatic logic [15:0] hw(logic [6:0] op, logic [2:0] a, logic [2:0] b, logic [2:0] c);
    return {op, a, b, c};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic fl, input logic fm, input logic fv, input logic [31:0] w);
    logic ev, er, n_cmp_m, n_up, n_ev;
    logic [31:0] ei;
    logic [15:0] h;
    logic [6:0] op;
    logic [8:0] n_eb;
    string tag;
    @(negedge clk);
    flush_i = fl; flush_mode_i = fm; fetch_valid_i = fv; fetch_word_i = w;
    #1;
    ev = 1'b0; er = 1'b0; ei = '0; tag = "R12";
    n_cmp_m = m_cmp; n_up = m_up; n_ev = m_ev; n_eb = m_eb;
    if (fl) begin
      tag = "R11"; n_cmp_m = fm; n_up = 1'b0; n_ev = 1'b0;
    end else if (!m_cmp) begin
      er = 1'b1;
      if (fv) begin
        if (w[31:25] == 7'h01) begin tag = "R3"; n_cmp_m = 1'b1; n_up = 1'b0; end
        else begin tag = "R2"; ev = 1'b1; ei = w; end
      end
    end else begin
      h  = m_up ? w[31:16] : w[15:0];
      op = h[15:9];
      er = m_up || (op == 7'h01);
      if (fv) begin
        n_up = !er;
        case (op)
          7'h00: tag = "R9";
          7'h01: begin tag = "R10"; n_cmp_m = 1'b0; n_ev = 1'b0; end
          7'h02: begin tag = "R8"; ev = 1'b1; ei = {7'h02, h[7:4], h[3:0], 4'h0, 13'h0}; n_ev = 1'b0; end
          7'h03: begin tag = "R7"; n_ev = 1'b1; n_eb = h[8:0]; end
          default: begin
            ev = 1'b1; n_ev = 1'b0;
            if (op[6]) begin
              tag = m_ev ? "R7" : "R6";
              ei = {tbl(op), 1'b0, h[8:6], 1'b0, h[5:3], 4'h0,
                    m_ev ? {m_eb, h[2], h[2:0]} : {{10{h[2]}}, h[2:0]}};
            end else begin
              tag = "R5";
              ei = {tbl(op), 1'b0, h[8:6], 1'b0, h[5:3], 1'b0, h[2:0], 13'h0};
            end
          end
        endcase
      end
    end
    chk(tag, {31'b0, instr_valid_o}, {31'b0, ev});
    if (ev) chk(tag, instr_o, ei);
    if (fv || fl) chk(m_cmp && !fl ? "R4" : tag, {31'b0, fetch_ready_o}, {31'b0, er});
    chk(tag, {31'b0, mode_o}, {31'b0, m_cmp});
    @(posedge clk);
    m_cmp = n_cmp_m; m_up = n_up; m_ev = n_ev; m_eb = n_eb;
  endtask

  function automatic logic [15:0] rnd_half();
    int k;
    k = $urandom % 10;
    case (k)
      0: return 16'h0000;
      1: return hw(7'h01, 3'($urandom), 3'($urandom), 3'($urandom));
      2: return {7'h02, 9'($urandom)};
      3: return {7'h03, 9'($urandom)};
      default: return {7'(4 + $urandom % 124), 9'($urandom)};
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", {31'b0, mode_o}, 32'd0);
    chk("R1", {31'b0, fetch_ready_o}, 32'd1);

    step(0, 0, 1, 32'h8123_4567);                                       // R2
    step(0, 0, 1, {7'h01, 25'h0});                                      // R3
    step(0, 0, 1, {hw(7'h45, 3'd1, 3'd2, 3'b101), hw(7'h10, 3'd5, 3'd6, 3'd7)}); // R4 R5
    step(0, 0, 1, {hw(7'h45, 3'd1, 3'd2, 3'b101), hw(7'h10, 3'd5, 3'd6, 3'd7)}); // R6 upper
    step(0, 0, 1, {hw(7'h50, 3'd3, 3'd4, 3'b011), 7'h03, 9'h1A5});      // R7 prefix
    step(0, 0, 1, {hw(7'h50, 3'd3, 3'd4, 3'b011), 7'h03, 9'h1A5});      // R7 consumer
    step(0, 0, 1, {16'h0000, hw(7'h60, 3'd7, 3'd0, 3'b110)});           // R7 cleared
    step(0, 0, 1, {16'h0000, hw(7'h60, 3'd7, 3'd0, 3'b110)});           // R9
    step(0, 0, 1, {hw(7'h01, 3'd0, 3'd0, 3'd0), 7'h02, 1'b0, 4'hF, 4'h9}); // R8
    step(0, 0, 1, {hw(7'h01, 3'd0, 3'd0, 3'd0), 7'h02, 1'b0, 4'hF, 4'h9}); // R10 upper
    step(0, 0, 1, {7'h01, 25'h0});
    step(0, 0, 1, {hw(7'h20, 3'd1, 3'd1, 3'd1), hw(7'h01, 3'd0, 3'd0, 3'd0)}); // R10 lower
    step(0, 0, 1, 32'h4000_0001);                                       // R2 after skip
    step(1, 1, 1, 32'h0202_0000);                                       // R11 flush to compact
    step(0, 0, 1, {16'h0000, 7'h03, 9'h0FF});                           // prefix pending
    step(1, 1, 1, {hw(7'h48, 3'd2, 3'd2, 3'b111), 16'h0000});           // R11 flush drops prefix
    step(0, 0, 1, {16'h0000, hw(7'h48, 3'd2, 3'd2, 3'b111)});           // R6 no prefix
    step(0, 0, 0, 32'hFFFF_FFFF);                                       // R12 idle
    step(0, 0, 1, {16'h0000, hw(7'h48, 3'd2, 3'd2, 3'b111)});
    step(1, 0, 0, 32'h0);                                               // R11 back to full

    for (int i = 0; i < 4000; i++) begin
      logic fl, fm, fv;
      logic [31:0] w;
      fl = ($urandom % 16) == 0;
      fm = 1'($urandom);
      fv = ($urandom % 8) != 0;
      if (!m_cmp) w = (($urandom % 6) == 0) ? {7'h01, 25'($urandom)} : $urandom;
      else        w = {rnd_half(), rnd_half()};
      step(fl, fm, fv, w);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule